// File: doc/BRIEF.md
# Slave-Mode DMA Command and Transfer-Count Controller

This block controls the path between an external DMA bus and an internal endpoint buffer. A microcontroller writes a byte-wide command code to start a transfer in either direction, stop it, reset the engine, or pulse validate/clear requests toward the buffer logic. A 32-bit counter holds the total byte count of a transfer. It is loaded while the engine is idle and can be read back at any time as the number of bytes still owed on the DMA bus.

Bytes pass through an 8-entry staging FIFO. In the IN direction the external controller writes bytes through a request/acknowledge handshake, and the FIFO passes them on to the endpoint buffer when the buffer is ready. In the OUT direction the engine fetches bytes from the buffer into the FIFO and offers them on the DMA bus. A sticky done flag marks normal completion. A sticky stop-complete flag marks a stop, and the way a stop ends depends on the transfer direction.

Top module: `dma_cmd_ctrl`

## Requirements
- R1: After the synchronous reset, `dreq`, `done_flag`, `stop_irq`, `validate_stb` and `clear_stb` are 0 and `cnt_rd` is 0. The internal command register holds FFh, which is a reserved code and starts nothing.
- R2: A command written with `cmd_we` takes effect on the second rising edge after the write edge, so its result is visible one cycle after the write is captured.
- R3: `cnt_we` loads `cnt_rd` on the next edge only while no transfer or stop drain is active. While a transfer is active the write is ignored.
- R4: Code 00h starts an IN transfer. Each byte accepted on the bus (`dreq` and `dack` both high at an edge) enters the FIFO and decrements `cnt_rd` by one. Bytes reach `buf_wr_data` in the order they were accepted, one per cycle in which `buf_wr_en` is high.
- R5: Code 01h starts an OUT transfer. Bytes taken from `buf_rd_data` in cycles where `buf_rd_en` is high appear on `dma_dout` in the same order. `cnt_rd` decrements once per byte accepted on the bus.
- R6: The FIFO stages at most 8 bytes. With the buffer not ready, an IN transfer accepts exactly 8 bytes and then holds `dreq` low.
- R7: A transfer ends when the counter is 0 and the FIFO is empty. At that point `done_flag` is set and `dreq` is low. In the IN direction this means every byte has been written to the buffer, and in the OUT direction every byte has left the FIFO.
- R8: A start command issued while the counter is 0 sets `done_flag` immediately and moves no data.
- R9: Code 13h during an IN transfer stops bus requests and drains the staged bytes to the buffer. Only then does it set `stop_irq`. The counter keeps the number of bytes not yet accepted.
- R10: Code 13h during an OUT transfer sets `stop_irq` at once, drops the staged bytes, and ends all buffer reads and bus requests. The counter keeps the number of bytes not yet delivered. Code 13h while idle only sets `stop_irq`.
- R11: Code 0Eh pulses `validate_stb` for one cycle and code 0Fh pulses `clear_stb` for one cycle.
- R12: Code 11h drives `dreq` high for exactly one cycle. The engine then returns to its power-on state: counter 0, flags clear, FIFO empty.
- R13: Reserved codes (02h–0Dh, 10h, 12h, 14h–FFh), and start codes issued while a transfer is active, change nothing.
- R14: `done_flag` and `stop_irq` stay set until the next accepted start command or a 11h reset clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command register write strobe |
| cmd_data | input | 8 | Command code |
| cnt_we | input | 1 | Transfer counter write strobe |
| cnt_wdata | input | 32 | Total byte count to load |
| cnt_rd | output | 32 | Bytes still to transfer on the DMA bus |
| dreq | output | 1 | DMA request to the external controller |
| dack | input | 1 | DMA acknowledge; a byte moves when high together with dreq |
| dma_din | input | 8 | Byte from the DMA bus (IN direction) |
| dma_dout | output | 8 | Byte to the DMA bus (OUT direction) |
| buf_ready | input | 1 | Endpoint buffer can take a byte |
| buf_wr_en | output | 1 | Write a byte into the endpoint buffer |
| buf_wr_data | output | 8 | Byte written into the endpoint buffer |
| buf_avail | input | 1 | Endpoint buffer has a byte to give |
| buf_rd_en | output | 1 | Take the byte on buf_rd_data |
| buf_rd_data | input | 8 | Byte offered by the endpoint buffer |
| done_flag | output | 1 | Sticky transfer-complete flag |
| stop_irq | output | 1 | Sticky stop-complete interrupt flag |
| validate_stb | output | 1 | One-cycle validate-buffer request |
| clear_stb | output | 1 | One-cycle clear-buffer request |

## Verification
A command result is due two rising edges after the write is driven: one edge captures the code and the next one executes it. The command task therefore returns two falling edges after driving the write, and it checks strobes, flags and the reset pulse at exactly that point. A validate strobe, for example, must be low at the first falling edge and high at the second. Handshake outputs depend only on registered state and on the inputs of the current cycle. The bench sets the inputs on a falling edge, reads `dreq`, `buf_wr_en`, `buf_rd_en` and the data buses 1 ns later, and counts the transfer as done at the next rising edge. Counter reloads are due one edge after `cnt_we` and are read at the following falling edge.

// File: rtl/dma_cmd_pkg.sv
package dma_cmd_pkg;

  localparam int CODE_W = 8;

  localparam logic [CODE_W-1:0] OP_START_IN  = 8'h00;
  localparam logic [CODE_W-1:0] OP_START_OUT = 8'h01;
  localparam logic [CODE_W-1:0] OP_VALIDATE  = 8'h0E;
  localparam logic [CODE_W-1:0] OP_CLEAR     = 8'h0F;
  localparam logic [CODE_W-1:0] OP_RESET     = 8'h11;
  localparam logic [CODE_W-1:0] OP_STOP      = 8'h13;
  localparam logic [CODE_W-1:0] OP_IDLE_VAL  = 8'hFF;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_XFER  = 2'd1,
    ST_DRAIN = 2'd2,
    ST_RST   = 2'd3
  } eng_state_t;

  typedef struct packed {
    logic start_in;
    logic start_out;
    logic validate;
    logic clear;
    logic reset;
    logic stop;
  } op_req_t;

endpackage

// File: rtl/dma_cmd_decode.sv
module dma_cmd_decode
  import dma_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [CODE_W-1:0] code_in,
  output op_req_t           req
);

  logic [CODE_W-1:0] code_q;
  logic              pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= OP_IDLE_VAL;
      pend_q <= 1'b0;
    end else begin
      pend_q <= wr;
      if (wr) code_q <= code_in;
    end
  end

  always_comb begin
    req = '0;
    if (pend_q) begin
      unique case (code_q)
        OP_START_IN:  req.start_in  = 1'b1;
        OP_START_OUT: req.start_out = 1'b1;
        OP_VALIDATE:  req.validate  = 1'b1;
        OP_CLEAR:     req.clear     = 1'b1;
        OP_RESET:     req.reset     = 1'b1;
        OP_STOP:      req.stop      = 1'b1;
        default:      req           = '0;
      endcase
    end
  end

  assert_onehot_req_R13: assert property (@(posedge clk) disable iff (rst)
    $onehot0(req));

endmodule

// File: rtl/dma_xfer_counter.sv
module dma_xfer_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] value,
  output logic         zero
);

  logic [W-1:0] val_q;

  always_ff @(posedge clk) begin
    if (rst || clr)  val_q <= '0;
    else if (load)   val_q <= load_val;
    else if (dec)    val_q <= val_q - W'(1);
  end

  assign value = val_q;
  assign zero  = (val_q == '0);

  assert_no_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    dec |-> !zero);

endmodule

// File: rtl/dma_stage_fifo.sv
module dma_stage_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             empty,
  output logic             full
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp_q, rp_q;
  logic [CW-1:0]    fill_q;
  logic             do_push, do_pop;

  assign full    = (fill_q == CW'(DEPTH));
  assign empty   = (fill_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp_q];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp_q   <= '0;
      rp_q   <= '0;
      fill_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == LAST) ? '0 : wp_q + AW'(1);
      if (do_pop)  rp_q <= (rp_q == LAST) ? '0 : rp_q + AW'(1);
      unique case ({do_push, do_pop})
        2'b10:   fill_q <= fill_q + CW'(1);
        2'b01:   fill_q <= fill_q - CW'(1);
        default: fill_q <= fill_q;
      endcase
    end
  end

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    !(push && full));

  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (rst)
    !(pop && empty));

endmodule

// File: rtl/dma_cmd_ctrl.sv
module dma_cmd_ctrl
  import dma_cmd_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_we,
  input  logic [CODE_W-1:0] cmd_data,
  input  logic              cnt_we,
  input  logic [CNT_W-1:0]  cnt_wdata,
  output logic [CNT_W-1:0]  cnt_rd,
  output logic              dreq,
  input  logic              dack,
  input  logic [DATA_W-1:0] dma_din,
  output logic [DATA_W-1:0] dma_dout,
  input  logic              buf_ready,
  output logic              buf_wr_en,
  output logic [DATA_W-1:0] buf_wr_data,
  input  logic              buf_avail,
  output logic              buf_rd_en,
  input  logic [DATA_W-1:0] buf_rd_data,
  output logic              done_flag,
  output logic              stop_irq,
  output logic              validate_stb,
  output logic              clear_stb
);

  eng_state_t        state_q;
  logic              dir_in_q;
  logic              done_q, stop_q, val_q, clr_q;
  op_req_t           req;

  logic              st_idle, st_xfer, st_drain, st_rst;
  logic              start_any, start_ok;
  logic              cnt_zero, fetch_zero;
  logic [CNT_W-1:0]  fetch_left;
  logic              fifo_empty, fifo_full, fifo_flush;
  logic              fifo_push, fifo_pop;
  logic [DATA_W-1:0] fifo_wdata, fifo_head;
  logic              bus_acc, fetch, xfer_end, out_stop;

  dma_cmd_decode u_decode (
    .clk     (clk),
    .rst     (rst),
    .wr      (cmd_we),
    .code_in (cmd_data),
    .req     (req)
  );

  assign st_idle   = (state_q == ST_IDLE);
  assign st_xfer   = (state_q == ST_XFER);
  assign st_drain  = (state_q == ST_DRAIN);
  assign st_rst    = (state_q == ST_RST);
  assign start_any = req.start_in || req.start_out;
  assign start_ok  = start_any && st_idle;
  assign out_stop  = req.stop && st_xfer && !dir_in_q;

  dma_xfer_counter #(.W(CNT_W)) u_remain (
    .clk      (clk),
    .rst      (rst),
    .clr      (st_rst),
    .load     (cnt_we && st_idle),
    .load_val (cnt_wdata),
    .dec      (bus_acc),
    .value    (cnt_rd),
    .zero     (cnt_zero)
  );

  dma_xfer_counter #(.W(CNT_W)) u_fetch (
    .clk      (clk),
    .rst      (rst),
    .clr      (st_rst),
    .load     (start_ok),
    .load_val (cnt_rd),
    .dec      (fetch),
    .value    (fetch_left),
    .zero     (fetch_zero)
  );

  always_comb begin
    dreq = st_rst;
    if (st_xfer) begin
      if (dir_in_q) dreq = !cnt_zero && !fifo_full;
      else          dreq = !fifo_empty;
    end
  end

  assign bus_acc     = dreq && dack && !st_rst;
  assign fetch       = st_xfer && !dir_in_q && !fetch_zero && !fifo_full && buf_avail;
  assign buf_rd_en   = fetch;
  assign buf_wr_en   = (st_xfer || st_drain) && dir_in_q && !fifo_empty && buf_ready;
  assign buf_wr_data = fifo_head;
  assign dma_dout    = fifo_head;

  assign fifo_push   = dir_in_q ? bus_acc : fetch;
  assign fifo_wdata  = dir_in_q ? dma_din : buf_rd_data;
  assign fifo_pop    = dir_in_q ? buf_wr_en : bus_acc;
  assign fifo_flush  = st_rst || out_stop;
  assign xfer_end    = st_xfer && cnt_zero && fifo_empty;

  dma_stage_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_stage (
    .clk   (clk),
    .rst   (rst),
    .flush (fifo_flush),
    .push  (fifo_push),
    .wdata (fifo_wdata),
    .pop   (fifo_pop),
    .rdata (fifo_head),
    .empty (fifo_empty),
    .full  (fifo_full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      dir_in_q <= 1'b1;
      done_q   <= 1'b0;
      stop_q   <= 1'b0;
      val_q    <= 1'b0;
      clr_q    <= 1'b0;
    end else begin
      val_q <= req.validate;
      clr_q <= req.clear;
      if (st_rst) begin
        state_q  <= ST_IDLE;
        dir_in_q <= 1'b1;
        done_q   <= 1'b0;
        stop_q   <= 1'b0;
      end else if (req.reset) begin
        state_q <= ST_RST;
      end else if (start_ok) begin
        dir_in_q <= req.start_in;
        done_q   <= cnt_zero;
        stop_q   <= 1'b0;
        state_q  <= cnt_zero ? ST_IDLE : ST_XFER;
      end else if (req.stop && st_xfer) begin
        if (dir_in_q) begin
          state_q <= ST_DRAIN;
        end else begin
          state_q <= ST_IDLE;
          stop_q  <= 1'b1;
        end
      end else if (req.stop && st_idle) begin
        stop_q <= 1'b1;
      end else if (xfer_end) begin
        state_q <= ST_IDLE;
        done_q  <= 1'b1;
      end else if (st_drain && fifo_empty) begin
        state_q <= ST_IDLE;
        stop_q  <= 1'b1;
      end
    end
  end

  assign done_flag    = done_q;
  assign stop_irq     = stop_q;
  assign validate_stb = val_q;
  assign clear_stb    = clr_q;

  assert_idle_quiet_R13: assert property (@(posedge clk) disable iff (rst)
    st_idle |-> (!dreq && !buf_wr_en && !buf_rd_en));

  assert_done_clean_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> (cnt_zero && fifo_empty));

  assert_drain_no_req_R9: assert property (@(posedge clk) disable iff (rst)
    st_drain |-> !dreq);

  assert_rst_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    st_rst |=> st_idle);

  assert_in_stop_empty_R9: assert property (@(posedge clk) disable iff (rst)
    ($rose(stop_q) && dir_in_q) |-> fifo_empty);

endmodule

// File: tb/test_dma_cmd_ctrl.sv
module test_dma_cmd_ctrl;

  logic        clk = 1'b0;
  logic        rst;
  logic        cmd_we;
  logic [7:0]  cmd_data;
  logic        cnt_we;
  logic [31:0] cnt_wdata;
  logic [31:0] cnt_rd;
  logic        dreq, dack;
  logic [7:0]  dma_din, dma_dout;
  logic        buf_ready, buf_wr_en;
  logic [7:0]  buf_wr_data;
  logic        buf_avail, buf_rd_en;
  logic [7:0]  buf_rd_data;
  logic        done_flag, stop_irq, validate_stb, clear_stb;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dma_cmd_ctrl i_dma_cmd_ctrl (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_data(cmd_data),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .cnt_rd(cnt_rd),
    .dreq(dreq), .dack(dack), .dma_din(dma_din), .dma_dout(dma_dout),
    .buf_ready(buf_ready), .buf_wr_en(buf_wr_en), .buf_wr_data(buf_wr_data),
    .buf_avail(buf_avail), .buf_rd_en(buf_rd_en), .buf_rd_data(buf_rd_data),
    .done_flag(done_flag), .stop_irq(stop_irq),
    .validate_stb(validate_stb), .clear_stb(clear_stb)
  );

  function automatic logic [7:0] pat(int idx, int salt);
    return 8'((idx * 37) + (salt * 11) + 5);
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic quiet();
    dack = 1'b0; buf_ready = 1'b0; buf_avail = 1'b0;
    cmd_we = 1'b0; cnt_we = 1'b0;
  endtask

  task automatic write_cmd(logic [7:0] code);
    cmd_we = 1'b1; cmd_data = code;
    @(negedge clk);
    cmd_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic load_cnt(logic [31:0] v);
    cnt_we = 1'b1; cnt_wdata = v;
    @(negedge clk);
    cnt_we = 1'b0;
  endtask

  // IN transfer already started: feed bytes, check buffer order and count (R4, R7)
  task automatic run_in(int len, int salt, string req);
    int sent = 0, got = 0, errs = 0, cyc = 0;
    while (!done_flag && cyc < 3000) begin
      if (cnt_rd != 32'(len - sent)) errs++;
      dack = 1'($urandom % 2); buf_ready = 1'($urandom % 2);
      dma_din = pat(sent, salt);
      #1;
      if (buf_wr_en) begin
        if (buf_wr_data != pat(got, salt)) errs++;
        got++;
      end
      if (dreq && dack) sent++;
      @(negedge clk);
      cyc++;
    end
    quiet();
    chk(errs == 0, {req, " R4 order/count"}, 32'(errs), 0);
    chk(got == len && sent == len, {req, " R4 bytes"}, 32'(got), 32'(len));
    chk(done_flag && !dreq && cnt_rd == 0, {req, " R7 done"}, {31'd0, done_flag}, 1);
  endtask

  // OUT transfer already started: supply buffer bytes, check bus order (R5, R7)
  task automatic run_out(int len, int salt, string req);
    int fetched = 0, sent = 0, errs = 0, cyc = 0;
    while (!done_flag && cyc < 3000) begin
      if (cnt_rd != 32'(len - sent)) errs++;
      dack = 1'($urandom % 2); buf_avail = 1'($urandom % 2);
      buf_rd_data = pat(fetched, salt);
      #1;
      if (buf_rd_en) fetched++;
      if (dreq && dack) begin
        if (dma_dout != pat(sent, salt)) errs++;
        sent++;
      end
      @(negedge clk);
      cyc++;
    end
    quiet();
    chk(errs == 0, {req, " R5 order/count"}, 32'(errs), 0);
    chk(fetched == len && sent == len, {req, " R5 bytes"}, 32'(sent), 32'(len));
    chk(done_flag && !dreq && cnt_rd == 0, {req, " R7 done"}, {31'd0, done_flag}, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int acc, wr, errs, fetched, sent, bad;
    void'($urandom(32'd20240611));
    rst = 1'b1; cmd_data = 8'h00; cnt_wdata = '0;
    dma_din = '0; buf_rd_data = '0;
    quiet();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    chk(!dreq && !done_flag && !stop_irq && cnt_rd == 0, "R1 reset outputs",
        {28'd0, dreq, done_flag, stop_irq, 1'b0}, 0);
    dack = 1'b1; buf_ready = 1'b1; buf_avail = 1'b1;
    bad = 0;
    repeat (4) begin #1; if (dreq || buf_wr_en || buf_rd_en) bad++; @(negedge clk); end
    quiet();
    chk(bad == 0 && !validate_stb && !clear_stb, "R1 idle after reset", 32'(bad), 0);

    // R2 / R11: strobe timing
    cmd_we = 1'b1; cmd_data = 8'h0E;
    @(negedge clk); cmd_we = 1'b0;
    chk(!validate_stb, "R2 not before second edge", {31'd0, validate_stb}, 0);
    @(negedge clk);
    chk(validate_stb, "R11 validate pulse", {31'd0, validate_stb}, 1);
    @(negedge clk);
    chk(!validate_stb, "R11 validate one cycle", {31'd0, validate_stb}, 0);
    write_cmd(8'h0F);
    chk(clear_stb && !validate_stb, "R11 clear pulse", {31'd0, clear_stb}, 1);
    @(negedge clk);
    chk(!clear_stb, "R11 clear one cycle", {31'd0, clear_stb}, 0);

    // Directed IN
    load_cnt(32'd5);
    chk(cnt_rd == 5, "R3 load idle", cnt_rd, 5);
    write_cmd(8'h00);
    run_in(5, 1, "dir-in");
    repeat (3) @(negedge clk);
    chk(done_flag, "R14 done sticky", {31'd0, done_flag}, 1);

    // Directed OUT, start clears done
    load_cnt(32'd9);
    write_cmd(8'h01);
    chk(!done_flag, "R14 start clears done", {31'd0, done_flag}, 0);
    run_out(9, 2, "dir-out");

    // R8: zero count
    load_cnt(32'd0);
    write_cmd(8'h00);
    chk(done_flag && !dreq, "R8 zero-count done", {31'd0, done_flag}, 1);
    dack = 1'b1; buf_ready = 1'b1; bad = 0;
    repeat (3) begin #1; if (dreq || buf_wr_en) bad++; @(negedge clk); end
    quiet();
    chk(bad == 0, "R8 no data moved", 32'(bad), 0);

    // R6 / R9: fill with buffer stalled, then stop IN and drain
    load_cnt(32'd20);
    write_cmd(8'h00);
    acc = 0;
    repeat (15) begin
      dack = 1'b1; dma_din = pat(acc, 3); #1;
      if (dreq && dack) acc++;
      @(negedge clk);
    end
    quiet();
    chk(acc == 8 && !dreq, "R6 fifo holds 8", 32'(acc), 8);
    chk(cnt_rd == 12, "R6 counter after 8", cnt_rd, 12);
    write_cmd(8'h13);
    chk(!stop_irq, "R9 irq waits for drain", {31'd0, stop_irq}, 0);
    wr = 0; errs = 0;
    repeat (12) begin
      buf_ready = 1'b1; dack = 1'b1; #1;
      if (dreq) errs++;
      if (buf_wr_en) begin
        if (buf_wr_data != pat(wr, 3)) errs++;
        wr++;
      end
      @(negedge clk);
    end
    quiet();
    chk(wr == 8 && errs == 0, "R9 staged bytes drained", 32'(wr), 8);
    chk(stop_irq && !done_flag && cnt_rd == 12, "R9 stop irq and count", cnt_rd, 12);

    // R3 / R13: counter write and bad commands during active IN
    load_cnt(32'd30);
    write_cmd(8'h00);
    chk(!stop_irq, "R14 start clears stop", {31'd0, stop_irq}, 0);
    load_cnt(32'd99);
    chk(cnt_rd == 30, "R3 load ignored while active", cnt_rd, 30);
    write_cmd(8'h05); write_cmd(8'h10); write_cmd(8'h12);
    write_cmd(8'hFF); write_cmd(8'h01);
    chk(cnt_rd == 30 && dreq && !stop_irq && !done_flag, "R13 ignored codes",
        cnt_rd, 30);
    run_in(30, 4, "after-ignored");

    // R10: stop OUT
    load_cnt(32'd20);
    write_cmd(8'h01);
    fetched = 0; sent = 0; errs = 0;
    repeat (10) begin
      buf_avail = 1'b1; buf_rd_data = pat(fetched, 5); #1;
      if (buf_rd_en) fetched++;
      @(negedge clk);
    end
    buf_avail = 1'b0;
    repeat (3) begin
      dack = 1'b1; #1;
      if (dreq && dack) begin
        if (dma_dout != pat(sent, 5)) errs++;
        sent++;
      end
      @(negedge clk);
    end
    quiet();
    chk(fetched == 8 && sent == 3 && errs == 0, "R10 pre-stop traffic", 32'(sent), 3);
    write_cmd(8'h13);
    chk(stop_irq && !dreq && cnt_rd == 17, "R10 stop out", cnt_rd, 17);
    bad = 0;
    repeat (5) begin
      buf_avail = 1'b1; dack = 1'b1; #1;
      if (buf_rd_en || dreq) bad++;
      @(negedge clk);
    end
    quiet();
    chk(bad == 0, "R10 no reads after stop", 32'(bad), 0);

    // R12: engine reset
    write_cmd(8'h11);
    chk(dreq, "R12 dreq pulse", {31'd0, dreq}, 1);
    @(negedge clk);
    chk(!dreq && cnt_rd == 0 && !stop_irq && !done_flag, "R12 power-on state",
        cnt_rd, 0);
    load_cnt(32'd4);
    write_cmd(8'h00);
    run_in(4, 6, "after-reset R12");

    // Constrained random transfers
    for (int i = 0; i < 12; i++) begin
      int len;
      len = int'($urandom % 25) + 1;
      load_cnt(32'(len));
      if ($urandom % 2 == 0) begin
        write_cmd(8'h00);
        run_in(len, 10 + i, "rand-in");
      end else begin
        write_cmd(8'h01);
        run_out(len, 10 + i, "rand-out");
      end
    end

    // R10: stop while idle only sets the flag
    write_cmd(8'h13);
    chk(stop_irq && done_flag && cnt_rd == 0, "R10 idle stop", {31'd0, stop_irq}, 1);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule